// File: doc/BRIEF.md
# Level-Capture Interrupt Bank

This block watches eight asynchronous input signals, such as power-fail or wake indications, and records when any of them reaches its active level. The record is taken without the bus clock: each channel's active-level detector drives the asynchronous set of a flag cell. A short pulse is therefore held even while the bus clock is stopped. The flag stays set until software writes a one to that channel's clear bit. While the active level persists, the flag simply stays set, so the clear has no lasting effect.

The flags cross into the bus clock domain through a two-flop synchronizer. A small state machine per channel then turns the synchronized flag into the status seen by software. Its states are `CH_QUIET` (no event), `CH_LATCHED` (event visible) and `CH_DRAIN` (a clear was written and stale synchronizer contents are hidden). Its transitions are:
- QUIET to LATCHED, when the synchronized flag is seen.
- QUIET or LATCHED to DRAIN, on a clear write.
- DRAIN back to DRAIN, on a further clear, which restarts the count.
- DRAIN to LATCHED or QUIET, after three cycles, chosen by the synchronized flag.

The interrupt output is the OR of the visible status bits that are also enabled. Only level detection exists, with a per-channel polarity bit.

Top module: `lvlcap_bank`

## Requirements
- R1: After reset, every readable register returns 0 and `irq_o` is 0.
- R2: A channel's active level is high when its polarity bit (offset 0x10, bit n for channel n) is 0, and low when it is 1. Any visit to the active level, however short, sets the channel's event, and the event stays set after the input returns to inactive.
- R3: An event is captured while the bus clock is stopped, and it becomes visible once the clock runs again.
- R4: Raw status (offset 0x04, bits 7:0) shows each channel's latched event whether or not the channel is enabled. The bit appears no later than four cycles after the input goes active.
- R5: Masked status (offset 0x08) reads raw status AND enable (offset 0x00, bit n for channel n).
- R6: `irq_o` is 1 exactly when masked status is non-zero, and it is 0 whenever enable is 0.
- R7: Writing offset 0x0C with bit n set removes channel n's event. Bits written as 0 leave their channels unchanged, and the clear offset reads 0.
- R8: If a channel's active level is present when its clear is written, the event is latched again and is visible once the drain ends.
- R9: In the cycle after a clear write, the cleared channel's status bit reads 0. It stays hidden for three cycles while the synchronizer flushes.
- R10: The mode offset 0x14 reads 0 and ignores writes, because only level capture exists. Offsets 0x18 and 0x1C read 0.
- R11: Enable and polarity read back bits 7:0 as written, and their upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` while selected |
| evt_in | input | 8 | Asynchronous event inputs, one per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle. One is a clear write to a channel; the other is a new event on that channel or on a neighbour. The bench presents a clear of two channels at the same bus edge as a rising input on one of the cleared channels and on an uncleared third channel. In the cycle after that edge, all three status bits must read 0, because the two cleared channels are draining and the new event is not yet through the synchronizer. After the drain, the re-asserted cleared channel and the new channel must read 1, and the other cleared channel must stay 0.

// File: rtl/lvlcap_pkg.sv
package lvlcap_pkg;

    // Byte offsets of the register slots; software decodes these positions.
    localparam int OFF_ENABLE = 'h00;
    localparam int OFF_RAW    = 'h04;
    localparam int OFF_MASKED = 'h08;
    localparam int OFF_CLEAR  = 'h0C;
    localparam int OFF_POLAR  = 'h10;
    localparam int OFF_MODE   = 'h14;

    typedef enum logic [1:0] {
        CH_QUIET   = 2'd0,
        CH_LATCHED = 2'd1,
        CH_DRAIN   = 2'd2
    } ch_state_e;

endpackage

// File: rtl/lvlcap_capture.sv
// Clock-free event capture: each channel flag is set asynchronously by its
// active level and cleared synchronously by a bus clear strobe. Set wins.
module lvlcap_capture #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] set_i,
    input  logic [N_CH-1:0] clr_i,
    output logic [N_CH-1:0] flag_o
);

    for (genvar i = 0; i < N_CH; i++) begin : g_cell
        logic flag_bit;

        always_ff @(posedge clk or negedge rst_n or posedge set_i[i]) begin
            if (!rst_n) begin
                flag_bit <= 1'b0;
            end else if (set_i[i]) begin
                flag_bit <= 1'b1;
            end else if (clr_i[i]) begin
                flag_bit <= 1'b0;
            end
        end

        assign flag_o[i] = flag_bit;

        // R8: an active level seen at a bus edge leaves the flag set one cycle later
        a_r8_set_beats_clear: assert property (
            @(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_bit
        );
    end

endmodule

// File: rtl/lvlcap_sync.sv
// Multi-stage synchronizer for the latched flags into the bus clock domain.
module lvlcap_sync #(
    parameter int N_CH   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] d_i,
    output logic [N_CH-1:0] q_o
);

    logic [N_CH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe_q[s] <= '0;
            end
        end else begin
            pipe_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/lvlcap_chan_fsm.sv
// Per-channel visibility state machine: hides stale synchronizer contents
// after a clear so software never sees an event it has already removed.
module lvlcap_chan_fsm
    import lvlcap_pkg::*;
#(
    parameter int DRAIN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic clr_i,
    output logic seen_o
);

    localparam int CW = $clog2(DRAIN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(DRAIN_LEN - 1);

    ch_state_e      st_q, st_d;
    logic [CW-1:0]  cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_QUIET: begin
                if (clr_i)       st_d = CH_DRAIN;
                else if (sync_i) st_d = CH_LATCHED;
            end
            CH_LATCHED: begin
                if (clr_i)       st_d = CH_DRAIN;
            end
            CH_DRAIN: begin
                if (clr_i)              st_d = CH_DRAIN;
                else if (cnt_q == LAST) st_d = sync_i ? CH_LATCHED : CH_QUIET;
            end
            default: st_d = CH_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_QUIET;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (clr_i) begin
                cnt_q <= '0;
            end else if (st_q == CH_DRAIN && cnt_q != LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        seen_o = (st_q == CH_LATCHED);
    end

    // R9: a clear hides the channel in the following cycle
    a_r9_hidden_after_clear: assert property (
        @(posedge clk) disable iff (!rst_n)
        clr_i |=> !seen_o
    );

    // R9: the drain counter never passes its last value
    a_r9_drain_bounded: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st_q == CH_DRAIN) |-> (cnt_q <= LAST)
    );

    // R4: a synchronized flag in the quiet state becomes visible next cycle
    a_r4_quiet_to_latched: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st_q == CH_QUIET && sync_i && !clr_i) |=> seen_o
    );

endmodule

// File: rtl/lvlcap_bank.sv
module lvlcap_bank
    import lvlcap_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   evt_in,
    output logic              irq_o
);

    localparam int DRAIN_LEN = SYNC_STAGES + 1;
    localparam int PAD_W     = DATA_W - N_CH;

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(OFF_RAW);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFF_MASKED);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLEAR);
    localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(OFF_POLAR);
    localparam logic [ADDR_W-1:0] A_MOD = ADDR_W'(OFF_MODE);

    logic [N_CH-1:0] en_q, pol_q;
    logic [N_CH-1:0] active_lvl, clr_vec, flag_w, sync_w, seen_w, masked_w;
    logic [N_CH-1:0] rd_field;
    logic            wr_hit;
    logic            unused_bits;

    assign wr_hit = bus_sel & bus_wr;
    assign unused_bits = ^bus_wdata[DATA_W-1:N_CH];

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (wr_hit) begin
            if (bus_addr == A_EN)  en_q  <= bus_wdata[N_CH-1:0];
            if (bus_addr == A_POL) pol_q <= bus_wdata[N_CH-1:0];
        end
    end

    // Clear strobe lasts exactly the write cycle
    assign clr_vec    = (wr_hit && bus_addr == A_CLR) ? bus_wdata[N_CH-1:0] : '0;
    // Polarity 0 -> high is active, 1 -> low is active
    assign active_lvl = evt_in ^ pol_q;

    lvlcap_capture #(.N_CH(N_CH)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (active_lvl),
        .clr_i  (clr_vec),
        .flag_o (flag_w)
    );

    lvlcap_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (flag_w),
        .q_o   (sync_w)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        lvlcap_chan_fsm #(.DRAIN_LEN(DRAIN_LEN)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (sync_w[i]),
            .clr_i  (clr_vec[i]),
            .seen_o (seen_w[i])
        );
    end

    assign masked_w = seen_w & en_q;
    assign irq_o    = |masked_w;

    // Read mux; clear and mode slots, and unmapped offsets, read zero
    always_comb begin
        rd_field = '0;
        case (bus_addr)
            A_EN:    rd_field = en_q;
            A_RAW:   rd_field = seen_w;
            A_MSK:   rd_field = masked_w;
            A_POL:   rd_field = pol_q;
            A_CLR:   rd_field = '0;
            A_MOD:   rd_field = '0;
            default: rd_field = '0;
        endcase
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? {{PAD_W{1'b0}}, rd_field} : '0;

    // R6: the interrupt can only be raised by an enabled channel
    a_r6_irq_needs_enable: assert property (
        @(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_q != '0)
    );

    // R7: a clear write leaves the interrupt low next cycle when it covers every enabled bit
    a_r7_full_clear_drops_irq: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_addr == A_CLR && ((en_q & ~bus_wdata[N_CH-1:0]) == '0)
         && !(bus_wr && bus_addr == A_EN)) |=> !irq_o
    );

endmodule

// File: tb/lvlcap_bank_tb.sv
module lvlcap_bank_tb;

    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_in = '0;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    lvlcap_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_in    (evt_in),
        .irq_o     (irq_o)
    );

    // 125 MHz, gateable
    initial begin
        forever begin
            #4;
            if (clk_run) clk = ~clk;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse(input int ch, input logic lvl);
        @(negedge clk);
        evt_in[ch] = lvl;
        #2;
        evt_in[ch] = ~lvl;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(5'h00, 32'hFFFF_FF00);
        rd(5'h00, d); check("R11 enable upper bits", d, 32'h0);
        wr(5'h00, 32'h0000_005A);
        rd(5'h00, d); check("R11 enable readback", d, 32'h5A);
        wr(5'h00, 32'h0);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, d); check("R10 mode reads zero", d, 32'h0);
        rd(5'h18, d); check("R10 unmapped 0x18", d, 32'h0);
        rd(5'h1C, d); check("R10 unmapped 0x1C", d, 32'h0);
        rd(5'h0C, d); check("R7 clear reads zero", d, 32'h0);
        rd(5'h10, d); check("R11 polarity untouched", d, 32'h0);
        settle();
        rd(5'h04, d); check("R10 mode write made no event", d, 32'h0);
    endtask

    task automatic t_polarity();
        logic [31:0] d;
        pulse(0, 1'b1);
        settle();
        rd(5'h04, d); check("R2 R4 high pulse held, enable off", d, 32'h01);
        rd(5'h08, d); check("R5 masked with enable off", d, 32'h0);
        check("R6 irq with enable off", {31'b0, irq_o}, 32'h0);
        wr(5'h10, 32'h02);
        settle();
        rd(5'h04, d); check("R2 low level active when polarity 1", d, 32'h03);
        evt_in[1] = 1'b1;
        wr(5'h0C, 32'h02);
        settle();
        rd(5'h04, d); check("R7 clear only bit 1", d, 32'h01);
        pulse(1, 1'b0);
        settle();
        rd(5'h04, d); check("R2 short low pulse latched", d, 32'h03);
        rd(5'h10, d); check("R11 polarity readback", d, 32'h02);
        wr(5'h10, 32'h0);
        evt_in[1] = 1'b0;
        wr(5'h0C, 32'hFF);
        settle();
        rd(5'h04, d); check("R7 clear all", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        pulse(2, 1'b1);
        wr(5'h00, 32'h01);
        settle();
        rd(5'h04, d); check("R4 raw ignores enable", d, 32'h04);
        rd(5'h08, d); check("R5 masked disabled channel", d, 32'h0);
        check("R6 irq low for disabled channel", {31'b0, irq_o}, 32'h0);
        wr(5'h00, 32'h04);
        rd(5'h08, d); check("R5 masked enabled channel", d, 32'h04);
        check("R6 irq high", {31'b0, irq_o}, 32'h1);
        wr(5'h0C, 32'h04);
        rd(5'h04, d); check("R9 status hidden after clear", d, 32'h0);
        check("R6 irq drops after clear", {31'b0, irq_o}, 32'h0);
        settle();
        rd(5'h04, d); check("R7 cleared stays clear", d, 32'h0);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_relatch();
        logic [31:0] d;
        @(negedge clk);
        evt_in[0] = 1'b1;
        settle();
        rd(5'h04, d); check("R2 held high level", d, 32'h01);
        wr(5'h0C, 32'h01);
        rd(5'h04, d); check("R9 hidden in drain cycle 1", d, 32'h0);
        @(negedge clk);
        rd(5'h04, d); check("R9 hidden in drain cycle 2", d, 32'h0);
        settle();
        rd(5'h04, d); check("R8 relatched while level present", d, 32'h01);
        evt_in[0] = 1'b0;
        wr(5'h0C, 32'h01);
        settle();
        rd(5'h04, d); check("R7 clear after level gone", d, 32'h0);
    endtask

    task automatic t_clock_stop();
        logic [31:0] d;
        @(negedge clk);
        clk_run = 1'b0;
        #40;
        evt_in[6] = 1'b1;
        #3;
        evt_in[6] = 1'b0;
        #40;
        clk_run = 1'b1;
        settle();
        rd(5'h04, d); check("R3 capture without clock", d, 32'h40);
        wr(5'h0C, 32'h40);
        settle();
        rd(5'h04, d); check("R3 cleared after clock restart", d, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        pulse(4, 1'b1);
        settle();
        rd(5'h04, d); check("R4 channel 4 latched", d, 32'h10);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h18;
        evt_in[3] = 1'b1; evt_in[5] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        evt_in[3] = 1'b0; evt_in[5] = 1'b0;
        rd(5'h04, d); check("R9 all hidden right after collision", d, 32'h0);
        settle();
        rd(5'h04, d); check("R8 R7 collision outcome", d, 32'h28);
        wr(5'h0C, 32'hFF);
        settle();
        rd(5'h04, d); check("R7 final clear", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_polarity();
        t_mask();
        t_relatch();
        t_clock_stop();
        t_same_cycle();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule